// File: doc/BRIEF.md
# Adaptive Pulse-and-Verify Programming Sequencer

This block is a host-side controller that writes a memory image into a one-time-programmable byte array. It talks to the array only through that array's pins: an address bus, a data bus the host can drive or release, an active-low chip-enable/program strobe, an active-low output enable, and two mode flags. One flag raises the program voltage and the other raises the core supply. The image is fetched through a simple asynchronous read port: the byte for `img_addr` must be present on `img_data` in the same cycle.

After a `start`, the sequencer latches an inclusive address window and walks it upward. For each address it fetches the target byte. A target of all ones is skipped, because an erased cell already holds it. Any other target gets one program pulse of fixed width, then a read-back. Pulses and read-backs alternate until the byte matches or the per-address pulse budget runs out. Once the last address verifies, the sequencer drops both mode flags and reads the whole window again in normal read mode. Every address is compared with the image. The run ends with `done` plus either `pass` or `fail`. On a failure, `fail_addr` shows the offending address. The window must satisfy `first_addr <= last_addr`.

The pulse length is set in clock cycles from the clock rate and the pulse time in microseconds, with a default of 100 us. Separate parameters set the gap between the pins settling and a pulse edge, and the read access wait.

Top module: `otp_prog_seq`

## Requirements
- R1: While reset is held and after its release, the strobe and output enable are high (1), the data bus is released, both mode flags are low, and `done`, `pass` and `fail` are low.
- R2: Each program pulse holds the strobe low for exactly PULSE_CYC = CLK_KHZ*PULSE_US/1000 consecutive cycles. During it, output enable is high, the host drives the data bus, and both mode flags are high.
- R3: Address and data-out are unchanged for at least GAP_CYC cycles before the strobe falls, for the whole pulse, and in the cycle the strobe returns high.
- R4: After every pulse and before the next one, the addressed byte is read with output enable low, the strobe high, the program flag high and the bus released. An address receives exactly as many pulses as it needs to read back equal to its target.
- R5: If an address still differs after MAX_PULSES pulses, the run ends at once with `done` and `fail` high, `fail_addr` equal to that address, and `pulse_cnt` equal to MAX_PULSES. No later address is pulsed.
- R6: An address whose target byte is 8'hFF gets no pulse, and `pulse_cnt` reads 0 for it.
- R7: Only addresses from `first_addr` through `last_addr` inclusive are pulsed, in ascending order.
- R8: The final pass runs with both mode flags low. Its reads use the strobe low together with output enable low, and no pulse follows it.
- R9: A mismatch during the final pass ends the run with `fail` high, and `fail_addr` holds the lowest mismatching address in the window.
- R10: A run in which every address verifies in both phases ends with `done` and `pass` high and `fail` low. `pass` and `fail` are never high together, and the outcome holds until the next `start`.
- R11: `start` pulses that arrive during a run have no effect on that run.
- R12: `pulse_cnt` gives the number of pulses applied to the most recently programmed address in the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle or finished) |
| first_addr | input | AW | First address of the window |
| last_addr | input | AW | Last address of the window (inclusive) |
| img_addr | output | AW | Image read address |
| img_data | input | DW | Image byte for `img_addr`, same cycle |
| mem_addr | output | AW | Array address pins |
| mem_dq_out | output | DW | Data the host drives toward the array |
| mem_dq_drive | output | 1 | Host drives the data bus when high |
| mem_dq_in | input | DW | Data returned by the array |
| mem_ce_n | output | 1 | Active-low chip-enable/program strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| vpp_high | output | 1 | Program-voltage mode flag |
| vcc_boost | output | 1 | Elevated core-supply mode flag |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without error |
| fail | output | 1 | Run finished with an error |
| fail_addr | output | AW | Address that caused the failure |
| pulse_cnt | output | clog2(MAX_PULSES+1) | Pulses given to the latest programmed address |

## Verification
The array model in the bench needs a set number of pulses per cell, so the sequencer is tried on images mixing skipped 8'hFF bytes with bytes that need one to three pulses. Per-address pulse totals are compared with those counts, which separates proper adaptive stopping from over- or under-pulsing. A narrow window inside a fully non-erased image shows whether the address bounds are respected, and a single-address window exercises first equal to last. One cell that needs more pulses than the budget, and cells that lose a bit when the supply flag drops, separate a program-phase failure from a final-pass failure and show which address is reported. An all-erased image and stray `start` pulses during a run check skipping and start immunity.

// File: rtl/otp_seq_pkg.sv
// Package: shared state encoding and helpers for the programming sequencer.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package otp_seq_pkg;

    // Sequencer phases; order carries no meaning.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_VERIFY,
        ST_ADVANCE,
        ST_FINAL,
        ST_FINISH
    } seq_state_e;

    // Largest of three cycle counts, used to size the shared timer.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/seq_timer.sv
// Module: seq_timer
// Loadable down-counter. The phase that loads value V lasts V+1 cycles:
// expired is high once the count has reached zero.
// Assumes load and count are never needed in the same cycle.
module seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    // Count down to zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/addr_walker.sv
// Module: addr_walker
// Holds the current address and the latched window bounds.
// begin_run latches the window and jumps to its first address, rewind
// returns to the latched first address, step moves up by one.
// Assumes first <= last; no wrap protection beyond that.
module addr_walker #(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          begin_run,
    input  logic          rewind,
    input  logic          step,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] cur,
    output logic          at_last
);

    logic [AW-1:0] lo_q;
    logic [AW-1:0] hi_q;
    logic [AW-1:0] cur_q;

    // Window capture and address movement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            cur_q <= '0;
        end else if (begin_run) begin
            lo_q  <= first_addr;
            hi_q  <= last_addr;
            cur_q <= first_addr;
        end else if (rewind) begin
            cur_q <= lo_q;
        end else if (step) begin
            cur_q <= cur_q + 1'b1;
        end
    end

    assign cur     = cur_q;
    assign at_last = (cur_q == hi_q);

endmodule

// File: rtl/pulse_tally.sv
// Module: pulse_tally
// Counts pulses applied to the current address and flags the budget.
// Assumes inc is never raised once at_limit is high.
module pulse_tally #(
    parameter int MAXP = 25,
    parameter int CW   = $clog2(MAXP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          at_limit
);

    logic [CW-1:0] cnt_q;

    // Per-address pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt      = cnt_q;
    assign at_limit = (cnt_q == CW'(MAXP));

endmodule

// File: rtl/otp_prog_seq.sv
// Module: otp_prog_seq
// Programs a byte image into a one-time-programmable array through its pins.
// Phase one (both mode flags high): per address fetch target, skip 8'hFF,
// otherwise alternate timed pulses and read-backs until match or budget.
// Phase two (flags low): read every address of the window in normal read
// mode and compare with the image.
// Assumes img_data answers img_addr combinationally and mem_dq_in is valid
// ACC_CYC cycles after the read controls and address settle.
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int AW         = 19,
    parameter int DW         = 8,
    parameter int CLK_KHZ    = 100_000,
    parameter int PULSE_US   = 100,
    parameter int MAX_PULSES = 25,
    parameter int GAP_CYC    = 1,
    parameter int ACC_CYC    = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [AW-1:0]                     first_addr,
    input  logic [AW-1:0]                     last_addr,
    output logic [AW-1:0]                     img_addr,
    input  logic [DW-1:0]                     img_data,
    output logic [AW-1:0]                     mem_addr,
    output logic [DW-1:0]                     mem_dq_out,
    output logic                              mem_dq_drive,
    input  logic [DW-1:0]                     mem_dq_in,
    output logic                              mem_ce_n,
    output logic                              mem_oe_n,
    output logic                              vpp_high,
    output logic                              vcc_boost,
    output logic                              done,
    output logic                              pass,
    output logic                              fail,
    output logic [AW-1:0]                     fail_addr,
    output logic [$clog2(MAX_PULSES+1)-1:0]   pulse_cnt
);

    localparam int PULSE_CYC = (CLK_KHZ * PULSE_US) / 1000;
    localparam int TMAX      = max3(PULSE_CYC, GAP_CYC, ACC_CYC);
    localparam int TW        = $clog2(TMAX + 1);
    localparam int PCW       = $clog2(MAX_PULSES + 1);
    localparam logic [TW-1:0] PULSE_V = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] GAP_V   = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] ACC_V   = TW'(ACC_CYC - 1);

    seq_state_e    state_q, state_d;
    logic [DW-1:0] tgt_q;
    logic          done_q, pass_q, fail_q;
    logic [AW-1:0] fail_addr_q;

    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic          walk_begin, walk_rewind, walk_step;
    logic [AW-1:0] cur_addr;
    logic          at_last;
    logic          tally_clr, tally_inc, at_limit;
    logic [PCW-1:0] tally_cnt;
    logic          tgt_load, set_fail, set_pass, new_run;
    logic          phase_prog, phase_final;

    seq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    addr_walker #(.AW(AW)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .begin_run  (walk_begin),
        .rewind     (walk_rewind),
        .step       (walk_step),
        .first_addr (first_addr),
        .last_addr  (last_addr),
        .cur        (cur_addr),
        .at_last    (at_last)
    );

    pulse_tally #(.MAXP(MAX_PULSES), .CW(PCW)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tally_clr),
        .inc      (tally_inc),
        .cnt      (tally_cnt),
        .at_limit (at_limit)
    );

    // Next-state and control strobes for the walk, pulse and verify loop.
    always_comb begin
        state_d     = state_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        walk_begin  = 1'b0;
        walk_rewind = 1'b0;
        walk_step   = 1'b0;
        tally_clr   = 1'b0;
        tally_inc   = 1'b0;
        tgt_load    = 1'b0;
        set_fail    = 1'b0;
        set_pass    = 1'b0;
        new_run     = 1'b0;
        case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (start) begin
                    new_run    = 1'b1;
                    walk_begin = 1'b1;
                    state_d    = ST_FETCH;
                end
            end
            ST_FETCH: begin
                tally_clr = 1'b1;
                tgt_load  = 1'b1;
                if (img_data == {DW{1'b1}}) begin
                    state_d = ST_ADVANCE;
                end else begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_V;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_V;
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    state_d   = ST_HOLD;
                    tally_inc = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = GAP_V;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    state_d  = ST_VERIFY;
                    tmr_load = 1'b1;
                    tmr_val  = ACC_V;
                end
            end
            ST_VERIFY: begin
                if (tmr_expired) begin
                    if (mem_dq_in == tgt_q) begin
                        state_d = ST_ADVANCE;
                    end else if (at_limit) begin
                        set_fail = 1'b1;
                        state_d  = ST_FINISH;
                    end else begin
                        state_d  = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = GAP_V;
                    end
                end
            end
            ST_ADVANCE: begin
                tmr_load = 1'b1;
                tmr_val  = ACC_V;
                if (at_last) begin
                    walk_rewind = 1'b1;
                    state_d     = ST_FINAL;
                end else begin
                    walk_step = 1'b1;
                    state_d   = ST_FETCH;
                end
            end
            ST_FINAL: begin
                if (tmr_expired) begin
                    if (mem_dq_in != img_data) begin
                        set_fail = 1'b1;
                        state_d  = ST_FINISH;
                    end else if (at_last) begin
                        set_pass = 1'b1;
                        state_d  = ST_FINISH;
                    end else begin
                        walk_step = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = ACC_V;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and latched target byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= '1;
        end else begin
            state_q <= state_d;
            if (tgt_load) begin
                tgt_q <= img_data;
            end
        end
    end

    // Run outcome: cleared by a new run, set once at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q      <= 1'b0;
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else if (new_run) begin
            done_q      <= 1'b0;
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else if (set_fail) begin
            done_q      <= 1'b1;
            fail_q      <= 1'b1;
            fail_addr_q <= cur_addr;
        end else if (set_pass) begin
            done_q <= 1'b1;
            pass_q <= 1'b1;
        end
    end

    // Pin levels decoded from the registered phase.
    always_comb begin
        phase_prog   = 1'b0;
        phase_final  = 1'b0;
        mem_ce_n     = 1'b1;
        mem_oe_n     = 1'b1;
        mem_dq_drive = 1'b0;
        case (state_q)
            ST_FETCH, ST_ADVANCE: phase_prog = 1'b1;
            ST_SETUP, ST_HOLD: begin
                phase_prog   = 1'b1;
                mem_dq_drive = 1'b1;
            end
            ST_PULSE: begin
                phase_prog   = 1'b1;
                mem_dq_drive = 1'b1;
                mem_ce_n     = 1'b0;
            end
            ST_VERIFY: begin
                phase_prog = 1'b1;
                mem_oe_n   = 1'b0;
            end
            ST_FINAL: begin
                phase_final = 1'b1;
                mem_ce_n    = 1'b0;
                mem_oe_n    = 1'b0;
            end
            default: ;
        endcase
    end

    assign vpp_high   = phase_prog;
    assign vcc_boost  = phase_prog && !phase_final;
    assign mem_addr   = cur_addr;
    assign img_addr   = cur_addr;
    assign mem_dq_out = tgt_q;
    assign done       = done_q;
    assign pass       = pass_q;
    assign fail       = fail_q;
    assign fail_addr  = fail_addr_q;
    assign pulse_cnt  = tally_cnt;

endmodule

// File: rtl/otp_prog_seq_checker.sv
// Module: otp_prog_seq_checker
// Pin-protocol and outcome properties, bound onto otp_prog_seq.
// Assumes the synchronous active-low reset of the top module.
module otp_prog_seq_checker #(
    parameter int AW         = 19,
    parameter int DW         = 8,
    parameter int MAX_PULSES = 25
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            mem_ce_n,
    input logic                            mem_oe_n,
    input logic                            mem_dq_drive,
    input logic                            vpp_high,
    input logic                            vcc_boost,
    input logic [AW-1:0]                   mem_addr,
    input logic [DW-1:0]                   mem_dq_out,
    input logic                            done,
    input logic                            pass,
    input logic                            fail,
    input logic [$clog2(MAX_PULSES+1)-1:0] pulse_cnt
);

    // R2: a pulse has output enable high, host drive and both flags.
    a_r2_pulse_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && vpp_high) |-> (mem_oe_n && mem_dq_drive && vcc_boost));

    // R3: pins steady across the falling edge and through the pulse.
    a_r3_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && vpp_high) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R3: pins steady at the rising edge of the strobe.
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ce_n) && vpp_high) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R4: program-verify read has the strobe high and the bus released.
    a_r4_verify_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && vpp_high) |-> (mem_ce_n && !mem_dq_drive));

    // R8: reads with strobe low only happen at nominal supply.
    a_r8_final_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !vpp_high) |-> (!mem_oe_n && !vcc_boost));

    // R5: per-address count never exceeds the budget.
    a_r5_budget: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= ($clog2(MAX_PULSES+1))'(MAX_PULSES));

    // R10: outcomes exclusive and only with done.
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));
    a_r10_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (pass || fail) |-> done);

endmodule

bind otp_prog_seq otp_prog_seq_checker #(
    .AW(AW), .DW(DW), .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_ce_n     (mem_ce_n),
    .mem_oe_n     (mem_oe_n),
    .mem_dq_drive (mem_dq_drive),
    .vpp_high     (vpp_high),
    .vcc_boost    (vcc_boost),
    .mem_addr     (mem_addr),
    .mem_dq_out   (mem_dq_out),
    .done         (done),
    .pass         (pass),
    .fail         (fail),
    .pulse_cnt    (pulse_cnt)
);

// File: tb/otp_prog_seq_bench.sv
// Bench: behavioural array model with per-cell pulse thresholds, a
// per-clock pin monitor and end-of-run comparisons against expectations
// computed from the image, thresholds and decay set of each case.
module otp_prog_seq_bench;

    localparam int AW        = 5;
    localparam int DW        = 8;
    localparam int DEPTH     = 1 << AW;
    localparam int CLK_KHZ   = 100;
    localparam int PULSE_US  = 100;
    localparam int PULSE_CYC = 10;
    localparam int MAXP      = 4;
    localparam int PCW       = $clog2(MAXP + 1);
    localparam int TIMEOUT   = 40000;

    logic           clk = 1'b0;
    logic           rst_n, start;
    logic [AW-1:0]  first_addr, last_addr, img_addr, mem_addr, fail_addr;
    logic [DW-1:0]  img_data, mem_dq_out, mem_dq_in;
    logic           mem_dq_drive, mem_ce_n, mem_oe_n, vpp_high, vcc_boost;
    logic           done, pass, fail;
    logic [PCW-1:0] pulse_cnt;

    // Case set-up, written by the stimulus process only.
    logic [7:0] img   [DEPTH];
    int         hard  [DEPTH];
    bit         decay [DEPTH];
    logic       erase_req = 1'b0;
    int         win_lo = 0, win_hi = 0;

    // Array state, written by the monitor process only.
    logic [7:0] mem  [DEPTH];
    int         seen [DEPTH];

    int tb_tests = 0, tb_fails = 0, mon_tests = 0, mon_fails = 0;

    always #5 clk = ~clk;

    otp_prog_seq #(
        .AW(AW), .DW(DW), .CLK_KHZ(CLK_KHZ), .PULSE_US(PULSE_US),
        .MAX_PULSES(MAXP), .GAP_CYC(1), .ACC_CYC(2)
    ) u_otp_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .first_addr(first_addr), .last_addr(last_addr),
        .img_addr(img_addr), .img_data(img_data),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .vpp_high(vpp_high), .vcc_boost(vcc_boost),
        .done(done), .pass(pass), .fail(fail),
        .fail_addr(fail_addr), .pulse_cnt(pulse_cnt)
    );

    assign img_data  = img[img_addr];
    assign mem_dq_in = (!mem_oe_n && (!mem_ce_n || vpp_high)) ? mem[mem_addr] : 8'h00;

    task automatic mon_check(input bit ok, input string req, input int act, input int exp);
        mon_tests++;
        if (!ok) begin
            mon_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tb_check(input bit ok, input string req, input int act, input int exp);
        tb_tests++;
        if (!ok) begin
            tb_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor and array model, evaluated once per clock away from the edge.
    logic          p_ce_n = 1'b1, p_vpp = 1'b0, p_vcc = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq = '0;
    int            low_run = 0;
    bit            verified = 1'b1, final_seen = 1'b0;

    always @(negedge clk) begin
        if (erase_req) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i]  = 8'hFF;
                seen[i] = 0;
            end
            verified   = 1'b1;
            final_seen = 1'b0;
            low_run    = 0;
        end else if (rst_n) begin
            if (!mem_ce_n && vpp_high) begin
                mon_check(mem_oe_n && mem_dq_drive && vcc_boost, "R2 pulse pins", 0, 1);
                mon_check(mem_addr == p_addr && mem_dq_out == p_dq, "R3 stable in pulse",
                          int'(mem_addr), int'(p_addr));
                if (p_ce_n) begin
                    mon_check(verified, "R4 read-back before pulse", 0, 1);
                    mon_check(int'(mem_addr) >= win_lo && int'(mem_addr) <= win_hi,
                              "R7 pulse inside window", int'(mem_addr), win_lo);
                    mon_check(!final_seen, "R8 no pulse after final pass", 1, 0);
                end
                low_run++;
            end
            if (mem_ce_n && !p_ce_n && p_vpp) begin
                mon_check(low_run == PULSE_CYC, "R2 pulse width", low_run, PULSE_CYC);
                mon_check(mem_addr == p_addr && mem_dq_out == p_dq, "R3 hold at rise",
                          int'(mem_dq_out), int'(p_dq));
                seen[mem_addr] = seen[mem_addr] + 1;
                if (seen[mem_addr] >= hard[mem_addr]) begin
                    mem[mem_addr] = mem[mem_addr] & mem_dq_out;
                end
                low_run  = 0;
                verified = 1'b0;
            end
            if (!mem_oe_n && vpp_high) begin
                mon_check(mem_ce_n && !mem_dq_drive, "R4 verify pins", 0, 1);
                verified = 1'b1;
            end
            if (!mem_ce_n && !vpp_high) begin
                mon_check(!mem_oe_n && !vcc_boost, "R8 final read pins", 0, 1);
                final_seen = 1'b1;
            end
            if (p_vcc && !vcc_boost) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (decay[i]) mem[i] = mem[i] | 8'h01;
                end
            end
        end
        p_ce_n = mem_ce_n;
        p_vpp  = vpp_high;
        p_vcc  = vcc_boost;
        p_addr = mem_addr;
        p_dq   = mem_dq_out;
    end

    // One run: compute expectations, erase, start, wait, compare.
    task automatic run_case(input int lo, input int hi, input bit poke, input string tag);
        int         exp_seen [DEPTH];
        bit         exp_fail;
        int         exp_faddr, exp_pc, cyc;
        logic [7:0] m;
        exp_fail = 1'b0; exp_faddr = 0; exp_pc = 0;
        for (int a = 0; a < DEPTH; a++) exp_seen[a] = 0;
        for (int a = lo; a <= hi; a++) begin
            if (!exp_fail) begin
                if (img[a] == 8'hFF) begin
                    exp_pc = 0;
                end else if (hard[a] > MAXP) begin
                    exp_seen[a] = MAXP; exp_pc = MAXP;
                    exp_fail = 1'b1; exp_faddr = a;
                end else begin
                    exp_seen[a] = hard[a]; exp_pc = hard[a];
                end
            end
        end
        if (!exp_fail) begin
            for (int a = lo; a <= hi; a++) begin
                m = decay[a] ? (img[a] | 8'h01) : img[a];
                if (!exp_fail && m != img[a]) begin
                    exp_fail = 1'b1; exp_faddr = a;
                end
            end
        end
        @(negedge clk) erase_req = 1'b1;
        @(negedge clk) erase_req = 1'b0;
        win_lo = lo; win_hi = hi;
        first_addr = AW'(lo); last_addr = AW'(hi);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (!done && cyc < TIMEOUT) begin
            @(negedge clk);
            cyc++;
            start = (poke && (cyc == 30 || cyc == 200)) ? 1'b1 : 1'b0;
        end
        start = 1'b0;
        tb_check(cyc < TIMEOUT, {tag, " watchdog"}, cyc, TIMEOUT);
        tb_check(done == 1'b1, {tag, " R10 done"}, int'(done), 1);
        tb_check(pass == !exp_fail && fail == exp_fail, {tag, " R10 outcome"},
                 int'(fail), int'(exp_fail));
        if (exp_fail)
            tb_check(int'(fail_addr) == exp_faddr, {tag, " R5/R9 fail address"},
                     int'(fail_addr), exp_faddr);
        tb_check(int'(pulse_cnt) == exp_pc, {tag, " R12 pulse count"}, int'(pulse_cnt), exp_pc);
        for (int a = 0; a < DEPTH; a++)
            tb_check(seen[a] == exp_seen[a], {tag, " R4/R6/R7 pulses per address"},
                     seen[a], exp_seen[a]);
        repeat (3) @(negedge clk);
        tb_check(done && pass == !exp_fail && fail == exp_fail, {tag, " R10 outcome held"},
                 int'(pass), int'(!exp_fail));
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; first_addr = '0; last_addr = '0;
        for (int a = 0; a < DEPTH; a++) begin
            img[a] = 8'hFF; hard[a] = 1; decay[a] = 1'b0;
        end
        repeat (3) @(negedge clk);
        tb_check(mem_ce_n && mem_oe_n && !mem_dq_drive && !vpp_high && !vcc_boost &&
                 !done && !pass && !fail, "R1 idle in reset", 0, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        tb_check(mem_ce_n && mem_oe_n && !mem_dq_drive && !vpp_high && !vcc_boost &&
                 !done, "R1 idle after reset", 0, 1);

        // Mixed image, thresholds 1..3, some erased bytes skipped.
        for (int a = 0; a < DEPTH; a++) begin
            img[a] = (a % 5 == 0) ? 8'hFF : 8'((a * 37 + 11) % 256);
            hard[a] = 1 + (a % 3);
        end
        run_case(0, DEPTH - 1, 1'b0, "mixed R4 R6");

        // Narrow window, every byte non-erased.
        for (int a = 0; a < DEPTH; a++) begin
            img[a] = 8'h00; hard[a] = 2;
        end
        run_case(3, 9, 1'b0, "window R7");

        // Single address window.
        run_case(17, 17, 1'b0, "single R7");

        // Budget exhausted at address 7.
        for (int a = 0; a < DEPTH; a++) begin
            img[a] = 8'((a * 37 + 11) % 256);
            hard[a] = (a == 7) ? MAXP + 1 : 1;
        end
        run_case(0, DEPTH - 1, 1'b0, "budget R5");

        // Cells 12 and 20 lose bit 0 at nominal supply: first reported.
        for (int a = 0; a < DEPTH; a++) begin
            img[a] = 8'((a * 6) % 256);
            hard[a] = 1;
            decay[a] = (a == 12 || a == 20);
        end
        run_case(0, DEPTH - 1, 1'b0, "final R9");

        // All erased: nothing pulsed, pass.
        for (int a = 0; a < DEPTH; a++) begin
            img[a] = 8'hFF; decay[a] = 1'b0;
        end
        run_case(0, DEPTH - 1, 1'b0, "erased R6");

        // Stray start pulses during a run.
        for (int a = 0; a < DEPTH; a++) begin
            img[a] = (a % 4 == 1) ? 8'hFF : 8'((a * 53 + 3) % 256);
            hard[a] = 1 + (a % 2);
        end
        run_case(2, 28, 1'b1, "restart R11");

        $display("[TB] %0d tests run, %0d failed", tb_tests + mon_tests, tb_fails + mon_fails);
        $finish;
    end

endmodule